// File: doc/BRIEF.md
# Prescaled Up-Counting Interval Timer

This block is a general-purpose interval timer that sits on a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. A prescaler divides the block clock by a programmable amount, and each prescaled tick advances an up-counter. When a tick finds the counter equal to the programmed reload limit, the counter returns to zero and an update event occurs. If updates are permitted, that event latches a status flag and drives a one-clock interrupt pulse.

A two-state machine tracks whether the timer is running. In HALT, the transition *start* (enable bit seen set) leads to RUN. In RUN, the transition *stop* (enable bit seen clear) leads back to HALT. The self-loops *idle* (HALT, enable clear) and *keep* (RUN, enable set) hold the state. Because the machine samples the enable bit through its own register, counting starts and stops one clock after the enable write. Apart from the live words, the map contains thirteen words that only store what software writes. These belong to compare, mode, burst and option functions that this block does not implement.

Top module: `tick_timer`

## Requirements
- R1: Reset leaves every mapped word reading zero, the run state in HALT, the prescaler phase at zero and `irq` low.
- R2: Every mapped word stores the full 32 bits written to it and reads them back. The exceptions are the count (0x24), prescale (0x28) and reload (0x2C) words, which hold only CNT_W bits, with the upper bits reading zero. The storage-only words are 0x04, 0x08, 0x14, 0x18, 0x1C, 0x20, 0x34, 0x38, 0x3C, 0x40, 0x48, 0x4C and 0x50.
- R3: A read from any other offset in the window (for example 0x30, 0x44 or 0x54) returns zero. A write there changes no stored word.
- R4: Bit 0 of the control word (0x00) enables counting. If the enable write lands on clock edge E, the prescaler first advances at edge E+2. With a prescale value P, the counter then steps once every P+1 clocks, so the first step lands at edge E+2+P.
- R5: A step that finds the count equal to the reload value sets the count to 0, and the prescaler phase also restarts at 0. The update period is therefore (P+1)*(reload+1) clocks.
- R6: On an update with bit 0 of the interrupt-enable word (0x0C) set, bit 0 of the status word (0x10) becomes 1 and `irq` is high for exactly the following clock. With that bit clear, an update sets neither.
- R7: A write to the status word replaces it with the bitwise AND of the old value and the written data. Writing 0 to bit 0 clears the flag, and writing 1 leaves it as it was.
- R8: When an update and a status write that would clear the flag fall on the same edge, the flag ends up set.
- R9: With reload 0 the count stays at 0 and every prescaled tick is an update. With P = 0, `irq` stays high on consecutive clocks, and with P = 1 it is high on every second clock.
- R10: A write to the count word takes effect at that edge and wins over a step on the same edge. The next step compares the written value against the reload value.
- R11: After the enable bit is cleared, the count changes at most once more (on the following edge) and then holds. No further interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-clock update interrupt pulse |

## Verification
The bench builds the block with DATA_W = 32, ADDR_W = 8 and CNT_W = 16. The narrowed counter width makes the zero upper bits of the count, prescale and reload words visible through a plain write of all ones. The small prescale and reload values used (2 and 9, then 0 and 1) put full update periods, the one-clock start latency, and the edge where an update meets a status-clearing write within a few dozen clocks. The same settings reach the reload-zero case at both continuous and alternating interrupt rates.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Live words
    localparam int unsigned OFF_CTRL   = 32'h00;
    localparam int unsigned OFF_IRQEN  = 32'h0C;
    localparam int unsigned OFF_STAT   = 32'h10;
    localparam int unsigned OFF_COUNT  = 32'h24;
    localparam int unsigned OFF_PRESC  = 32'h28;
    localparam int unsigned OFF_RELOAD = 32'h2C;

    // Words that only hold what software writes
    localparam int N_PLAIN = 13;
    localparam int unsigned PLAIN_OFF [N_PLAIN] = '{
        32'h04, 32'h08, 32'h14, 32'h18, 32'h1C, 32'h20,
        32'h34, 32'h38, 32'h3C, 32'h40, 32'h48, 32'h4C, 32'h50
    };

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] presc,
    output logic             tick
);
    logic [CNT_W-1:0] phase_q;

    // A lowered prescale value below the current phase still ends the period.
    assign tick = run && (phase_q >= presc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             upd_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic             run,
    output logic             wrap,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    run_state_e state_q, state_nxt;
    logic [CNT_W-1:0] count_q;
    logic             irq_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_nxt;
    end

    // Transitions: idle / start out of HALT, keep / stop out of RUN
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_HALT: state_nxt = enable ? ST_RUN  : ST_HALT;
            ST_RUN:  state_nxt = enable ? ST_RUN  : ST_HALT;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        run  = 1'b0;
        wrap = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                run  = 1'b0;
                wrap = 1'b0;
            end
            ST_RUN: begin
                run  = 1'b1;
                wrap = tick && (count_q == reload);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (cnt_wr)        count_q <= cnt_wdata;
            else if (wrap)     count_q <= '0;
            else if (tick)     count_q <= count_q + 1'b1;
            irq_q <= wrap && upd_en;
        end
    end

    assign count = count_q;
    assign irq   = irq_q;
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output logic              enable,
    output logic              upd_en,
    output logic              flag,
    output logic [CNT_W-1:0]  presc,
    output logic [CNT_W-1:0]  reload,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata
);
    logic [DATA_W-1:0] ctrl_q, irqen_q, stat_q;
    logic [CNT_W-1:0]  presc_q, reload_q;
    logic [DATA_W-1:0] plain_q [N_PLAIN];

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
        return a == ADDR_W'(off);
    endfunction

    logic wr_ctrl, wr_irqen, wr_stat, wr_presc, wr_reload;
    assign wr_ctrl   = bus_we && hit(bus_addr, OFF_CTRL);
    assign wr_irqen  = bus_we && hit(bus_addr, OFF_IRQEN);
    assign wr_stat   = bus_we && hit(bus_addr, OFF_STAT);
    assign wr_presc  = bus_we && hit(bus_addr, OFF_PRESC);
    assign wr_reload = bus_we && hit(bus_addr, OFF_RELOAD);
    assign cnt_wr    = bus_we && hit(bus_addr, OFF_COUNT);
    assign cnt_wdata = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            irqen_q  <= '0;
            stat_q   <= '0;
            presc_q  <= '0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl)   ctrl_q   <= bus_wdata;
            if (wr_irqen)  irqen_q  <= bus_wdata;
            if (wr_presc)  presc_q  <= bus_wdata[CNT_W-1:0];
            if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
            // Hardware set is ORed after the software AND, so the set wins.
            stat_q <= (wr_stat ? (stat_q & bus_wdata) : stat_q)
                      | DATA_W'(wrap && irqen_q[0]);
        end
    end

    for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
        always_ff @(posedge clk) begin
            if (!rst_n)                                   plain_q[i] <= '0;
            else if (bus_we && hit(bus_addr, PLAIN_OFF[i])) plain_q[i] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, OFF_CTRL))   bus_rdata = ctrl_q;
        if (hit(bus_addr, OFF_IRQEN))  bus_rdata = irqen_q;
        if (hit(bus_addr, OFF_STAT))   bus_rdata = stat_q;
        if (hit(bus_addr, OFF_COUNT))  bus_rdata = DATA_W'(count);
        if (hit(bus_addr, OFF_PRESC))  bus_rdata = DATA_W'(presc_q);
        if (hit(bus_addr, OFF_RELOAD)) bus_rdata = DATA_W'(reload_q);
        for (int i = 0; i < N_PLAIN; i++) begin
            if (hit(bus_addr, PLAIN_OFF[i])) bus_rdata = plain_q[i];
        end
    end

    assign enable = ctrl_q[0];
    assign upd_en = irqen_q[0];
    assign flag   = stat_q[0];
    assign presc  = presc_q;
    assign reload = reload_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             enable_w, upd_en_w, flag_w, run_w, tick_w, wrap_w, cnt_wr_w;
    logic [CNT_W-1:0] presc_w, reload_w, count_w, cnt_wdata_w;

    tmr_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count_w),
        .wrap      (wrap_w),
        .enable    (enable_w),
        .upd_en    (upd_en_w),
        .flag      (flag_w),
        .presc     (presc_w),
        .reload    (reload_w),
        .cnt_wr    (cnt_wr_w),
        .cnt_wdata (cnt_wdata_w)
    );

    tmr_prescaler #(.CNT_W(CNT_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .presc (presc_w),
        .tick  (tick_w)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable_w),
        .upd_en    (upd_en_w),
        .tick      (tick_w),
        .reload    (reload_w),
        .cnt_wr    (cnt_wr_w),
        .cnt_wdata (cnt_wdata_w),
        .run       (run_w),
        .wrap      (wrap_w),
        .count     (count_w),
        .irq       (irq)
    );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              wdata0,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              run,
    input logic              wrap,
    input logic              upd_en,
    input logic              flag,
    input logic [CNT_W-1:0]  count
);
    logic cnt_write, stat_write, hole;
    assign cnt_write  = bus_we && (bus_addr == ADDR_W'(8'h24));
    assign stat_write = bus_we && (bus_addr == ADDR_W'(8'h10));
    assign hole       = (bus_addr == ADDR_W'(8'h30)) || (bus_addr == ADDR_W'(8'h44))
                        || (bus_addr == ADDR_W'(8'h54));

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);                                                   // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(upd_en) && $past(run)));                          // R6
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_write) |=> $stable(count));                        // R11
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cnt_write) |=> (count == '0));                         // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && upd_en) |=> flag);                                      // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_write && !wdata0 && !(wrap && upd_en)) |=> !flag);         // R7
    AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        hole |-> (bus_rdata == '0));                                     // R3
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .wdata0    (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .run       (run_w),
    .wrap      (wrap_w),
    .upd_en    (upd_en_w),
    .flag      (flag_w),
    .count     (count_w)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tick_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {we, write offset, write data, read offset, expected read}
    localparam int NV = 22;
    localparam logic [80:0] VEC [NV] = '{
        {1'b1, 8'h04, 32'hA5A5_0001, 8'h04, 32'hA5A5_0001},  // R2
        {1'b1, 8'h08, 32'h0000_FFFF, 8'h08, 32'h0000_FFFF},  // R2
        {1'b1, 8'h14, 32'h8000_0001, 8'h14, 32'h8000_0001},  // R2
        {1'b1, 8'h18, 32'h1111_2222, 8'h18, 32'h1111_2222},  // R2
        {1'b1, 8'h1C, 32'h3333_4444, 8'h1C, 32'h3333_4444},  // R2
        {1'b1, 8'h20, 32'h5555_6666, 8'h20, 32'h5555_6666},  // R2
        {1'b1, 8'h34, 32'h0000_1234, 8'h34, 32'h0000_1234},  // R2
        {1'b1, 8'h38, 32'hDEAD_BEEF, 8'h38, 32'hDEAD_BEEF},  // R2
        {1'b1, 8'h3C, 32'h0F0F_0F0F, 8'h3C, 32'h0F0F_0F0F},  // R2
        {1'b1, 8'h40, 32'hCAFE_0040, 8'h40, 32'hCAFE_0040},  // R2
        {1'b1, 8'h48, 32'h7777_0048, 8'h48, 32'h7777_0048},  // R2
        {1'b1, 8'h4C, 32'h9999_004C, 8'h4C, 32'h9999_004C},  // R2
        {1'b1, 8'h50, 32'hFFFF_FFFF, 8'h50, 32'hFFFF_FFFF},  // R2
        {1'b1, 8'h2C, 32'hFFFF_FFFF, 8'h2C, 32'h0000_FFFF},  // R2 narrow
        {1'b1, 8'h28, 32'hFFFF_FFFF, 8'h28, 32'h0000_FFFF},  // R2 narrow
        {1'b1, 8'h24, 32'hFFFF_FFFF, 8'h24, 32'h0000_FFFF},  // R2 narrow
        {1'b1, 8'h00, 32'hFFFF_FFFE, 8'h00, 32'hFFFF_FFFE},  // R2, enable clear
        {1'b1, 8'h0C, 32'hFFFF_FFFE, 8'h0C, 32'hFFFF_FFFE},  // R2
        {1'b1, 8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000},  // R7 AND keeps zero
        {1'b1, 8'h30, 32'hFFFF_FFFF, 8'h30, 32'h0000_0000},  // R3
        {1'b1, 8'h30, 32'hFFFF_FFFF, 8'h34, 32'h0000_1234},  // R3 no alias
        {1'b1, 8'h44, 32'h0BAD_0BAD, 8'h40, 32'hCAFE_0040}   // R3 no alias
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Called at a negedge; returns at the negedge after the capturing edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r, c1;
        int e0, hits;
        do_reset();

        // Reset state R1
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'h24, r); check("R1 count", r, 0);
        rd(8'h10, r); check("R1 status", r, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][80]) wr(VEC[i][79:72], VEC[i][71:40]);
            rd(VEC[i][39:32], r);
            check($sformatf("R2/R3 vector %0d", i), r, VEC[i][31:0]);
        end

        // Second reset clears everything written (R1)
        do_reset();
        foreach (tmr_pkg::PLAIN_OFF[k]) begin
            rd(8'(tmr_pkg::PLAIN_OFF[k]), r); check("R1 storage word", r, 0);
        end
        rd(8'h00, r); check("R1 ctrl", r, 0);
        rd(8'h2C, r); check("R1 reload", r, 0);

        // Prescale 2, reload 9
        wr(8'h28, 2); wr(8'h2C, 9); wr(8'h0C, 1); wr(8'h00, 1);
        e0 = cyc;
        wait_cyc(e0 + 3); rd(8'h24, r); check("R4 before first step", r, 0);
        wait_cyc(e0 + 4); rd(8'h24, r); check("R4 first step", r, 1);
        wait_cyc(e0 + 8); rd(8'h24, r); check("R4 third prescaled period", r, 2);
        wait_cyc(e0 + 30); check("R6 irq before update", {31'b0, irq}, 0);
        wait_cyc(e0 + 31); check("R6 irq on update", {31'b0, irq}, 1);
        rd(8'h10, r); check("R6 flag set", r, 1);
        rd(8'h24, r); check("R5 wrapped to zero", r, 0);
        wait_cyc(e0 + 32); check("R6 irq one clock", {31'b0, irq}, 0);

        // Clear write meeting an update (R5 period 30)
        wait_cyc(e0 + 60); wr(8'h10, 0);
        check("R5 second update at period", {31'b0, irq}, 1);
        rd(8'h10, r); check("R8 set wins", r, 1);
        wr(8'h10, 0); rd(8'h10, r); check("R7 clear by zero", r, 0);
        wait_cyc(e0 + 91); check("R5 third update", {31'b0, irq}, 1);
        wr(8'h10, 1); rd(8'h10, r); check("R7 one keeps flag", r, 1);
        wr(8'h10, 32'hFFFF_FFFE); rd(8'h10, r); check("R7 clear bit0", r, 0);

        // Count write (R10)
        wait_cyc(e0 + 94); wr(8'h24, 9);
        rd(8'h24, r); check("R10 written count", r, 9);
        wait_cyc(e0 + 96); check("R10 no early update", {31'b0, irq}, 0);
        wait_cyc(e0 + 97); check("R10 update from written value", {31'b0, irq}, 1);
        rd(8'h24, r); check("R10 wrap after written value", r, 0);

        // Disable (R11)
        wr(8'h00, 0); e0 = cyc;
        wait_cyc(e0 + 2); rd(8'h24, c1);
        hits = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (irq) hits++; end
        rd(8'h24, r); check("R11 count holds", r, c1);
        check("R11 no irq while off", hits, 0);

        // Reload zero without interrupt enable (R6, R9)
        wr(8'h0C, 0); wr(8'h2C, 0); wr(8'h28, 0); wr(8'h24, 0); wr(8'h10, 0); wr(8'h00, 1);
        hits = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (irq) hits++; end
        check("R6 no irq without enable", hits, 0);
        rd(8'h10, r); check("R6 no flag without enable", r, 0);
        rd(8'h24, r); check("R9 count stays zero", r, 0);

        wr(8'h0C, 1); e0 = cyc;
        hits = 0;
        for (int i = 1; i <= 3; i++) begin wait_cyc(e0 + i); if (irq) hits++; end
        check("R9 irq every clock at prescale 0", hits, 3);
        rd(8'h10, r); check("R9 flag set", r, 1);

        wr(8'h28, 1); e0 = cyc;
        wait_cyc(e0 + 2);
        hits = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (irq) hits++; end
        check("R9 irq every second clock", hits, 10);
        rd(8'h24, r); check("R9 count zero at prescale 1", r, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule